// File: doc/BRIEF.md
# Global History Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It uses two levels of state. The first level is a global shift register that records the resolved outcomes of the most recent branches, whichever branch produced them. The second level is a table of 2-bit saturating counters. The table is addressed by an index built from the branch address and that global history. A build-time switch picks how the index is formed. In XOR-fold mode the word-address bits are XORed with the history bits, so that branches with different addresses spread over the whole table. In split mode a few address bits are joined with a few history bits.

The fetch side presents a branch address on the lookup port and reads the taken guess in the same cycle, with no register in between. When the branch later resolves, the execute side presents its address and real direction on the training port. On that clock edge the addressed counter moves one step, and the outcome is shifted into the history. Each counter is a small state machine with four states:
- `CTR_SNT` (00, strongly not taken)
- `CTR_WNT` (01, weakly not taken)
- `CTR_WT` (10, weakly taken)
- `CTR_ST` (11, strongly taken)

A taken outcome moves a counter one state towards `CTR_ST`. A not-taken outcome moves it one state towards `CTR_SNT`. Both end states hold against further moves in their own direction.

Top module: `gpred_top`

## Requirements
- R1: After reset every counter is in `CTR_WNT` (01) and the history register is all zeros, so every lookup returns not taken until training occurs.
- R2: The lookup output is the most significant bit of the addressed counter: 1 (taken) for `CTR_WT`/`CTR_ST`, 0 for `CTR_SNT`/`CTR_WNT`.
- R3: A training event with outcome taken moves the addressed counter SNT→WNT→WT→ST, and a counter already in `CTR_ST` stays there.
- R4: A training event with outcome not taken moves the addressed counter ST→WT→WNT→SNT, and a counter already in `CTR_SNT` stays there.
- R5: On each training event the history shifts left by one, and the outcome (1 = taken) enters bit 0. Without a training event the history holds.
- R6: The counter trained by an event is the one selected with the history value from before that event's shift.
- R7: In XOR-fold mode (SHARE_MODE=1, 8-bit index) the index is pc[9:2] XOR history[7:0].
- R8: In split mode (SHARE_MODE=0, 8-bit index) the index is {pc[5:2], history[3:0]}, with the address bits in the upper half.
- R9: A lookup in the same cycle as a training event sees the history and counters from before that event.
- R10: While `res_valid` is low, `res_pc` and `res_taken` have no effect on any counter or on the history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | 32 | Address of the branch being looked up |
| pred_taken | output | 1 | Direction guess for `pred_pc` (1 = taken) |
| res_valid | input | 1 | Training event strobe, one per resolved branch |
| res_pc | input | 32 | Address of the resolved branch |
| res_taken | input | 1 | Real direction of the resolved branch (1 = taken) |

## Verification
The assertions assume that `res_valid` is a clean 0 or 1 every cycle and that training inputs are meaningful only while it is high. They do not assume that lookup and training addresses differ. The stimulus changes inputs only at the falling edge. It keeps `res_valid` low for whole stretches in which `res_taken` toggles, so that the hold property and the ignore requirement are both exercised. Same-cycle lookup and training of the same address are included on purpose, because the expected value must then come from the state before the edge.

// File: rtl/gpred_pkg.sv
package gpred_pkg;

    // Two-bit direction counter state; encoding is visible at R2
    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_e;

    localparam ctr_e CTR_RESET = CTR_WNT;

endpackage

// File: rtl/gpred_history.sv
module gpred_history #(
    parameter int HBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             shift_in,
    output logic [HBITS-1:0] hist_q
);

    logic [HBITS-1:0] hist_d;

    always_comb begin
        hist_d = hist_q;
        if (shift_en) begin
            hist_d = {hist_q[HBITS-2:0], shift_in};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (hist_q[0] == $past(shift_in)) && (hist_q[HBITS-1:1] == $past(hist_q[HBITS-2:0]))); // R5
    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist_q)); // R5

endmodule

// File: rtl/gpred_index.sv
module gpred_index #(
    parameter int IDX_BITS   = 8,
    parameter int HIST_BITS  = 8,
    parameter int PC_BITS    = 32,
    parameter bit SHARE_MODE = 1'b1
) (
    input  logic [PC_BITS-1:0]   pc,
    input  logic [HIST_BITS-1:0] hist,
    output logic [IDX_BITS-1:0]  idx
);

    localparam int PC_LSB  = 2;
    localparam int SEL_H   = IDX_BITS / 2;
    localparam int SEL_P   = IDX_BITS - SEL_H;

    generate
        if (SHARE_MODE) begin : g_share
            assign idx = pc[PC_LSB +: IDX_BITS] ^ hist[IDX_BITS-1:0];
        end else begin : g_select
            assign idx = {pc[PC_LSB +: SEL_P], hist[SEL_H-1:0]};
        end
    endgenerate

endmodule

// File: rtl/gpred_pht.sv
module gpred_pht
    import gpred_pkg::*;
#(
    parameter int IDX_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_BITS-1:0] rd_idx,
    output logic                rd_taken,
    input  logic                upd_en,
    input  logic [IDX_BITS-1:0] upd_idx,
    input  logic                upd_taken
);

    localparam int ENTRIES = 1 << IDX_BITS;

    ctr_e cnt_q [ENTRIES];
    ctr_e cur_st;
    ctr_e nxt_st;

    assign cur_st = cnt_q[upd_idx];

    // next-state logic of the addressed counter
    always_comb begin
        nxt_st = cur_st;
        unique case (cur_st)
            CTR_SNT: nxt_st = upd_taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt_st = upd_taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt_st = upd_taken ? CTR_ST  : CTR_WNT;
            CTR_ST:  nxt_st = upd_taken ? CTR_ST  : CTR_WT;
            default: nxt_st = CTR_RESET;
        endcase
    end

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                cnt_q[i] <= CTR_RESET;
            end
        end else if (upd_en) begin
            cnt_q[upd_idx] <= nxt_st;
        end
    end

    // output: direction is the upper counter bit
    always_comb begin
        unique case (cnt_q[rd_idx])
            CTR_WT, CTR_ST:   rd_taken = 1'b1;
            CTR_SNT, CTR_WNT: rd_taken = 1'b0;
            default:          rd_taken = 1'b0;
        endcase
    end

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_taken && cur_st == CTR_ST) |=> cnt_q[$past(upd_idx)] == CTR_ST); // R3
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_taken && cur_st == CTR_WNT) |=> cnt_q[$past(upd_idx)] == CTR_WT); // R3
    AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_taken && cur_st == CTR_SNT) |=> cnt_q[$past(upd_idx)] == CTR_SNT); // R4
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_taken && cur_st == CTR_WT) |=> cnt_q[$past(upd_idx)] == CTR_WNT); // R4

endmodule

// File: rtl/gpred_top.sv
module gpred_top #(
    parameter int IDX_BITS   = 8,
    parameter int HIST_BITS  = 8,
    parameter int PC_BITS    = 32,
    parameter bit SHARE_MODE = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PC_BITS-1:0] pred_pc,
    output logic               pred_taken,
    input  logic               res_valid,
    input  logic [PC_BITS-1:0] res_pc,
    input  logic               res_taken
);

    logic [HIST_BITS-1:0] hist;
    logic [IDX_BITS-1:0]  lk_idx;
    logic [IDX_BITS-1:0]  tr_idx;

    gpred_history #(.HBITS(HIST_BITS)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (res_valid),
        .shift_in (res_taken),
        .hist_q   (hist)
    );

    gpred_index #(
        .IDX_BITS(IDX_BITS), .HIST_BITS(HIST_BITS),
        .PC_BITS(PC_BITS), .SHARE_MODE(SHARE_MODE)
    ) u_lk_idx (
        .pc   (pred_pc),
        .hist (hist),
        .idx  (lk_idx)
    );

    // training index uses the history before this event's shift (R6)
    gpred_index #(
        .IDX_BITS(IDX_BITS), .HIST_BITS(HIST_BITS),
        .PC_BITS(PC_BITS), .SHARE_MODE(SHARE_MODE)
    ) u_tr_idx (
        .pc   (res_pc),
        .hist (hist),
        .idx  (tr_idx)
    );

    gpred_pht #(.IDX_BITS(IDX_BITS)) u_pht (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (lk_idx),
        .rd_taken  (pred_taken),
        .upd_en    (res_valid),
        .upd_idx   (tr_idx),
        .upd_taken (res_taken)
    );

    AST_IDLE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> ($stable(pred_pc) -> $stable(pred_taken))); // R10

endmodule

// File: tb/sim_gpred_top.sv
module sim_gpred_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic        tk_sh;
    logic        tk_se;

    always #4 clk = ~clk;

    gpred_top #(.SHARE_MODE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(tk_sh),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken)
    );

    gpred_top #(.SHARE_MODE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(tk_se),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken)
    );

    typedef struct {
        logic  e_sh;
        logic  e_se;
        string tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          errors = 0;
    logic [1:0]  m_sh [256];
    logic [1:0]  m_se [256];
    logic [7:0]  mh;
    logic [31:0] lfsr = 32'hACE1_2357;
    bit          done = 1'b0;

    function automatic logic [7:0] ix_sh(logic [31:0] pc, logic [7:0] h);
        return pc[9:2] ^ h;              // R7
    endfunction

    function automatic logic [7:0] ix_se(logic [31:0] pc, logic [7:0] h);
        return {pc[5:2], h[3:0]};        // R8
    endfunction

    function automatic logic [1:0] bump(logic [1:0] c, logic t);
        if (t) return (c == 2'b11) ? 2'b11 : c + 2'd1;   // R3
        return (c == 2'b00) ? 2'b00 : c - 2'd1;          // R4
    endfunction

    task automatic step(input logic [31:0] ppc, input logic rv,
                        input logic [31:0] rpc, input logic t, input string tag);
        exp_t e;
        @(negedge clk);
        pred_pc   = ppc;
        res_valid = rv;
        res_pc    = rpc;
        res_taken = t;
        // expected lookup from pre-update state (R9)
        e.e_sh = m_sh[ix_sh(ppc, mh)][1];
        e.e_se = m_se[ix_se(ppc, mh)][1];
        e.tag  = tag;
        sb.push_back(e);
        if (rv) begin
            m_sh[ix_sh(rpc, mh)] = bump(m_sh[ix_sh(rpc, mh)], t);  // R6
            m_se[ix_se(rpc, mh)] = bump(m_se[ix_se(rpc, mh)], t);
            mh = {mh[6:0], t};                                     // R5
        end
    endtask

    function automatic logic [31:0] nxt(logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    // monitor: compares outputs between edges
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (tk_sh !== e.e_sh) begin
                    errors++;
                    $display("FAIL %s xor-fold pc=%h actual=%b expected=%b", e.tag, pred_pc, tk_sh, e.e_sh);
                end
                checks++;
                if (tk_se !== e.e_se) begin
                    errors++;
                    $display("FAIL %s split pc=%h actual=%b expected=%b", e.tag, pred_pc, tk_se, e.e_se);
                end
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            m_sh[i] = 2'b01;   // R1
            m_se[i] = 2'b01;
        end
        mh = 8'h00;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, every lookup not taken
        for (int i = 0; i < 6; i++) step(32'h40 * i + 32'h1000, 1'b0, '0, 1'b0, "R1");
        // R2: a single taken from weakly not taken flips the guess
        step(32'h0000_0010, 1'b1, 32'h0000_0010, 1'b1, "R2");
        step(32'h0000_0010, 1'b0, '0, 1'b0, "R2");
        for (int i = 0; i < 10; i++) step(32'h0000_0010, 1'b1, 32'h0000_0010, 1'b1, "R2 R9");

        // R3: repeated taken on one branch, history settles to all ones
        for (int i = 0; i < 14; i++) step(32'h0000_0124, 1'b1, 32'h0000_0124, 1'b1, "R3");
        // R4: strong taken survives one not-taken, then falls
        for (int i = 0; i < 14; i++) step(32'h0000_0124, 1'b1, 32'h0000_0124, 1'b0, "R4");
        for (int i = 0; i < 4; i++)  step(32'h0000_0124, 1'b1, 32'h0000_0124, 1'b1, "R3 R4");

        // R10: idle training inputs toggling, nothing may change
        for (int i = 0; i < 12; i++) begin
            lfsr = nxt(lfsr);
            step({20'h0, lfsr[11:2], 2'b00}, 1'b0, lfsr, lfsr[5], "R10");
        end

        // R5 R6 R7 R8: mixed stream with aliasing addresses
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a;
            logic [31:0] b;
            lfsr = nxt(lfsr);
            a = {22'h0, lfsr[7:0], 2'b00};
            lfsr = nxt(lfsr);
            b = (lfsr[3]) ? a : {22'h0, lfsr[9:2], 2'b00};
            step(a, lfsr[0] | lfsr[1], b, lfsr[4] ^ lfsr[9], "R5 R6 R7 R8");
        end

        // R9: lookup and training of same branch in the same cycle
        for (int i = 0; i < 20; i++) begin
            lfsr = nxt(lfsr);
            step({26'h0, lfsr[3:0], 2'b00}, 1'b1, {26'h0, lfsr[3:0], 2'b00}, lfsr[6], "R9");
        end

        step('0, 1'b0, '0, 1'b0, "R10");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule